// File: doc/BRIEF.md
# Compare/Capture Channel with PWM and Watchdog

This block is a single channel of a counter array that shares one free-running time base. The time base value comes in as a 16-bit bus, split into a low byte and a high byte. The channel holds one 16-bit compare/capture register. Depending on its mode bits, the channel does one of several jobs:

- It stamps the time base into that register on an edge of its pin.
- It raises a flag when the time base reaches the stored value.
- It toggles its pin on each such match.
- It drives an 8-bit pulse-width waveform from the low byte.
- On a channel built with the watchdog option, it issues a reset pulse when the armed value is reached.

Software reaches the channel through a small byte-wide write port. This port has four targets: the mode byte, the low compare byte, the high compare byte and a flag-clear strobe. The compare register and the mode byte are visible on output buses for readback. The time base prescaler and the interrupt controller sit outside the block.

Top module: `cc_channel`

## Requirements
- R1: After reset, pin_out, cc_flag and wdog_rst are 0, and cmp_q and mode_q are 0.
- R2: A write with wr_sel=0 loads bits 6:0 of wr_data into the mode byte. The mode bits are: bit6 arm, bit5 capture-on-rise, bit4 capture-on-fall, bit3 match-flag enable, bit2 toggle, bit1 PWM, bit0 watchdog enable. mode_q bit 7 reads 0.
- R3: A write with wr_sel=1 loads the low compare byte and clears the arm bit. A write with wr_sel=2 loads the high compare byte and sets the arm bit. Both take effect at the next clock edge.
- R4: pin_in passes through two synchronising flops. A rising edge with capture-on-rise set, or a falling edge with capture-on-fall set, copies tb_val into cmp_q and sets cc_flag. This happens on the third clock edge after pin_in changes. Edges of a disabled polarity change nothing.
- R5: cc_flag is sticky. Only a write with wr_sel=3 clears it, and a set in the same cycle wins over that clear.
- R6: When arm and match-flag enable are set and tb_val takes a new value equal to cmp_q, cc_flag is set at that edge. A time base held at the matching value does not raise the flag again.
- R7: When a match condition of R6 occurs with the toggle bit also set, the non-PWM pin level inverts at that edge.
- R8: With the PWM bit set, pin_out is registered high when the tb_val low byte is greater than or equal to the low compare byte, and low otherwise. A low byte of 0 therefore gives a constant high.
- R9: With the PWM bit set, a low-byte rollover of tb_val from FF to 00 copies the high compare byte into the low compare byte. A software low-byte write in that same cycle takes precedence.
- R10: With HAS_WDOG=1, when arm and watchdog enable are set and tb_val takes a new value equal to cmp_q, wdog_rst is high for exactly one cycle after that edge. It is never high otherwise.
- R11: When a capture and a software compare-byte write fall in the same cycle, cmp_q takes the captured value, while the arm bit still follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tb_val | input | 16 | Shared time base value |
| pin_in | input | 1 | Asynchronous channel pin level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 low byte, 2 high byte, 3 flag clear |
| wr_data | input | 8 | Write data |
| pin_out | output | 1 | Channel pin drive |
| cc_flag | output | 1 | Sticky match/capture flag |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |
| cmp_q | output | 16 | Compare/capture register readback |
| mode_q | output | 8 | Mode byte readback |

## Verification
Two collisions matter most in this channel.

- **Capture against a software write.** A pin edge is placed so that its capture edge coincides with a software write to the low compare byte. The bench then expects the captured time base value in cmp_q and a cleared arm bit in mode_q.
- **Capture against a flag clear.** A second edge is timed to coincide with a flag-clear write. The flag must remain set.

A behavioural reference model runs alongside in the bench and is compared with every output on every clock. A random phase that confines the time base and compare values to a few codes makes matches, captures, rollovers and writes overlap often.

// File: rtl/cc_channel.sv
`timescale 1ns/1ps
module cc_channel #(
  parameter int HALF_W = 8,
  parameter bit HAS_WDOG = 1'b1,
  localparam int CW = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     tb_val,
  input  logic              pin_in,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [HALF_W-1:0] wr_data,
  output logic              pin_out,
  output logic              cc_flag,
  output logic              wdog_rst,
  output logic [CW-1:0]     cmp_q,
  output logic [7:0]        mode_q
);
  logic [CW-1:0] tb_prev;
  logic [6:0] mode_r;
  logic s1, s2, s3, tog_q, pwm_q;

  wire arm    = mode_r[6];
  wire cap_r  = mode_r[5];
  wire cap_f  = mode_r[4];
  wire mat_en = mode_r[3];
  wire tog_en = mode_r[2];
  wire pwm_en = mode_r[1];
  wire wdte   = mode_r[0];

  wire wr_mode = wr_en && wr_sel == 2'd0;
  wire wr_lo   = wr_en && wr_sel == 2'd1;
  wire wr_hi   = wr_en && wr_sel == 2'd2;
  wire wr_clr  = wr_en && wr_sel == 2'd3;

  wire rise   = s2 & ~s3;
  wire fall   = ~s2 & s3;
  wire cap_ev = (cap_r & rise) | (cap_f & fall);
  wire eq_new = (tb_val != tb_prev) && (tb_val == cmp_q);
  wire hit    = arm && mat_en && eq_new;
  wire lo_ovf = pwm_en && (&tb_prev[HALF_W-1:0]) && (tb_val[HALF_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      tb_prev <= '0;
      cmp_q <= '0;
      mode_r <= '0;
      cc_flag <= 1'b0;
      tog_q <= 1'b0;
      pwm_q <= 1'b0;
      wdog_rst <= 1'b0;
    end else begin
      s1 <= pin_in; s2 <= s1; s3 <= s2;
      tb_prev <= tb_val;
      if (cap_ev) cmp_q <= tb_val;
      else begin
        if (wr_hi) cmp_q[CW-1:HALF_W] <= wr_data;
        if (wr_lo) cmp_q[HALF_W-1:0] <= wr_data;
        else if (lo_ovf) cmp_q[HALF_W-1:0] <= cmp_q[CW-1:HALF_W];
      end
      if (wr_mode) mode_r <= wr_data[6:0];
      else if (wr_lo) mode_r[6] <= 1'b0;
      else if (wr_hi) mode_r[6] <= 1'b1;
      if (cap_ev || hit) cc_flag <= 1'b1;
      else if (wr_clr) cc_flag <= 1'b0;
      if (hit && tog_en) tog_q <= ~tog_q;
      pwm_q <= tb_val[HALF_W-1:0] >= cmp_q[HALF_W-1:0];
      wdog_rst <= HAS_WDOG && arm && wdte && eq_new;
    end
  end

  assign pin_out = pwm_en ? pwm_q : tog_q;
  assign mode_q  = {1'b0, mode_r};

  AST_LO_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_lo) |-> !mode_q[6]); // R3
  AST_HI_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_hi) |-> mode_q[6]); // R3
  AST_CAPTURE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_ev) |-> cc_flag); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cc_flag) && !$past(wr_clr)) |-> cc_flag); // R5
  AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_en && $past(!pwm_en) && !$past(hit && tog_en)) |-> $stable(pin_out)); // R7
  AST_WD_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |-> $past(arm && wdte)); // R10
endmodule

// File: tb/cc_channel_tb.sv
`timescale 1ns/1ps
module cc_channel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] tb_val = '0;
  logic pin_in = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic pin_out, cc_flag, wdog_rst;
  logic [15:0] cmp_q;
  logic [7:0] mode_q;
  bit tb_run = 1'b0;
  bit done = 1'b0;
  int nchk = 0, nerr = 0;

  cc_channel u_dut (.clk(clk), .rst_n(rst_n), .tb_val(tb_val), .pin_in(pin_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .pin_out(pin_out),
    .cc_flag(cc_flag), .wdog_rst(wdog_rst), .cmp_q(cmp_q), .mode_q(mode_q));

  always #2.5 clk = ~clk;

  // reference model
  int m_cmp, m_mode, m_flag, m_tog, m_pwm, m_wd, m_prev;
  bit ph[$] = '{0, 0, 0};
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmp = 0; m_mode = 0; m_flag = 0; m_tog = 0; m_pwm = 0; m_wd = 0; m_prev = 0;
      ph = '{0, 0, 0};
    end else begin
      int t, hi, lo, n_mode;
      bit up, dn, cap, eq, hit, ovf, wl, wh;
      t = int'(tb_val);
      up = ph[1] && !ph[2];
      dn = !ph[1] && ph[2];
      cap = (m_mode[5] && up) || (m_mode[4] && dn);
      eq = (t != m_prev) && (t == m_cmp);
      hit = m_mode[6] && m_mode[3] && eq;
      ovf = m_mode[1] && (m_prev % 256 == 255) && (t % 256 == 0);
      wl = wr_en && wr_sel == 1;
      wh = wr_en && wr_sel == 2;
      hi = m_cmp / 256;
      lo = m_cmp % 256;
      if (cap) begin
        hi = t / 256; lo = t % 256;
      end else begin
        if (wl) lo = int'(wr_data);
        else if (ovf) lo = m_cmp / 256;
        if (wh) hi = int'(wr_data);
      end
      n_mode = m_mode;
      if (wr_en && wr_sel == 0) n_mode = int'(wr_data) % 128;
      else if (wl) n_mode = m_mode & 'h3F;
      else if (wh) n_mode = m_mode | 'h40;
      if (cap || hit) m_flag = 1;
      else if (wr_en && wr_sel == 3) m_flag = 0;
      if (hit && m_mode[2]) m_tog = 1 - m_tog;
      m_pwm = ((t % 256) >= (m_cmp % 256)) ? 1 : 0;
      m_wd = (m_mode[6] && m_mode[0] && eq) ? 1 : 0;
      m_cmp = hi * 256 + lo;
      m_mode = n_mode;
      m_prev = t;
      ph.push_front(pin_in);
      void'(ph.pop_back());
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int ep;
      ep = m_mode[1] ? m_pwm : m_tog;
      chk(pin_out == ep, "R7 R8 pin model", pin_out, ep);
      chk(cc_flag == m_flag, "R4 R5 R6 flag model", cc_flag, m_flag);
      chk(wdog_rst == m_wd, "R10 wdog model", wdog_rst, m_wd);
      chk(cmp_q == m_cmp, "R9 R11 cmp model", cmp_q, m_cmp);
      chk(mode_q == m_mode, "R2 R3 mode model", mode_q, m_mode);
    end
  end

  task automatic cyc();
    @(negedge clk);
    #1;
    wr_en = 1'b0;
    if (tb_run) tb_val = tb_val + 16'd1;
  endtask

  task automatic wr(int sel, int data);
    cyc();
    wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(data);
  endtask

  task automatic settb(int v);
    cyc();
    tb_val = 16'(v);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #200000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog timeout");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(pin_out == 0 && cc_flag == 0 && wdog_rst == 0, "R1 outputs", {pin_out, cc_flag, wdog_rst}, 0);
    chk(cmp_q == 0 && mode_q == 0, "R1 regs", {cmp_q, mode_q}, 0);
    rst_n = 1'b1;
    idle(2);

    // R2 R3 register writes
    wr(0, 'h48); wr(1, 'h34); cyc();
    chk(mode_q == 'h08, "R3 low write disarms", mode_q, 'h08);
    wr(2, 'h12); cyc();
    chk(mode_q == 'h48, "R2 R3 high write arms", mode_q, 'h48);
    chk(cmp_q == 'h1234, "R3 compare bytes", cmp_q, 'h1234);

    // R6 match
    settb('h1233); settb('h1234); idle(2);
    chk(cc_flag == 1, "R6 match sets flag", cc_flag, 1);
    wr(3, 0); idle(4);
    chk(cc_flag == 0, "R6 held value no rematch", cc_flag, 0);

    // R7 toggle
    wr(0, 'h4C); settb('h1235); settb('h1234); idle(2);
    chk(pin_out == 1, "R7 toggle high", pin_out, 1);
    settb('h1235); settb('h1234); idle(2);
    chk(pin_out == 0, "R7 toggle low", pin_out, 0);

    // R5 sticky
    wr(0, 'h00); idle(5);
    chk(cc_flag == 1, "R5 flag sticky", cc_flag, 1);

    // R4 capture
    wr(3, 0); wr(0, 'h20); settb('h0ABC); pin_in = 1'b1;
    cyc(); cyc();
    chk(cc_flag == 0, "R4 sync delay", cc_flag, 0);
    cyc();
    chk(cc_flag == 1 && cmp_q == 'h0ABC, "R4 rise capture", cmp_q, 'h0ABC);
    settb('h0BCD); pin_in = 1'b0; idle(4);
    chk(cmp_q == 'h0ABC, "R4 fall ignored", cmp_q, 'h0ABC);
    wr(0, 'h10); cyc(); pin_in = 1'b1; idle(4);
    chk(cmp_q == 'h0ABC, "R4 rise ignored", cmp_q, 'h0ABC);
    settb('h0777); pin_in = 1'b0; idle(4);
    chk(cmp_q == 'h0777, "R4 fall capture", cmp_q, 'h0777);

    // R11 capture against low write
    wr(3, 0); wr(0, 'h60); settb('h0999); pin_in = 1'b1;
    cyc(); cyc();
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h55;
    cyc();
    chk(cmp_q == 'h0999, "R11 capture wins", cmp_q, 'h0999);
    chk(mode_q == 'h20, "R11 arm follows write", mode_q, 'h20);

    // R5 set beats clear
    wr(0, 'h30); wr(3, 0); settb('h0AAA); pin_in = 1'b0;
    cyc(); cyc();
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h00;
    cyc();
    chk(cc_flag == 1 && cmp_q == 'h0AAA, "R5 set wins over clear", cc_flag, 1);

    // R8 R9 PWM
    wr(0, 'h02); wr(1, 'h40); wr(2, 'hC0);
    settb('h0030); idle(2);
    chk(pin_out == 0, "R8 below duty", pin_out, 0);
    settb('h0040); idle(2);
    chk(pin_out == 1, "R8 equal duty", pin_out, 1);
    settb('h00FF); settb('h0100); cyc();
    chk(cmp_q == 'hC0C0, "R9 rollover reload", cmp_q, 'hC0C0);
    cyc();
    chk(pin_out == 0, "R8 new duty low", pin_out, 0);
    settb('h01C0); idle(2);
    chk(pin_out == 1, "R8 new duty high", pin_out, 1);
    settb('h01FF); settb('h0200);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h11;
    cyc();
    chk(cmp_q == 'hC011, "R9 write beats reload", cmp_q, 'hC011);
    wr(1, 0); wr(2, 0); tb_run = 1'b1;
    for (int i = 0; i < 600; i++) begin
      cyc();
      if (pin_out != 1) chk(0, "R8 zero duty high", pin_out, 1);
    end
    chk(pin_out == 1, "R8 zero duty high", pin_out, 1);
    tb_run = 1'b0;

    // R10 watchdog
    wr(0, 'h01); wr(1, 0); wr(2, 'h20);
    settb('h1FFF); settb('h2000); cyc();
    chk(wdog_rst == 1, "R10 pulse", wdog_rst, 1);
    cyc();
    chk(wdog_rst == 0, "R10 one cycle", wdog_rst, 0);
    wr(1, 0); settb('h1FFF); settb('h2000); cyc();
    chk(wdog_rst == 0, "R10 disarmed", wdog_rst, 0);

    // random overlap phase
    for (int i = 0; i < 4000; i++) begin
      cyc();
      tb_val = 16'($urandom_range(0, 7)) | ((i % 512 < 8) ? 16'h00F8 : 16'h0000);
      if ($urandom_range(0, 3) == 0) pin_in = ~pin_in;
      if ($urandom_range(0, 5) == 0) begin
        wr_en = 1'b1;
        wr_sel = 2'($urandom_range(0, 3));
        wr_data = (wr_sel == 0) ? 8'($urandom_range(0, 255)) : 8'($urandom_range(0, 7));
      end
    end
    idle(3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule